// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an 8-bit asynchronous parallel flash bus. It accepts one request at a time: program a byte, erase the sector that holds an address, or erase the whole chip. It expands the request into the unlock and command writes that the flash expects. It then polls the flash until the internal operation finishes and reads the target byte back for a final comparison. The result is reported as a one-clock `done` pulse, together with `verify_fail` and `timeout` flags.

Strobe timing comes from clock-count parameters. The data bus is split into an output, an output enable and an input, so the pad ring can build the tri-state buffer. Two completion methods are supported, selected per request. The first watches bit 7 of the polled byte against bit 7 of the expected value. The second reads the byte twice in a row and waits until bit 6 stops changing.

The sequencer FSM has these states:
- `ST_IDLE`. An accepted request moves it to `ST_CMD`.
- `ST_CMD`. It issues one command write per bus cycle. After the last write it moves to `ST_POLL_A`.
- `ST_POLL_A`. In data-polling mode, a bit-7 match moves it to `ST_VERIFY`. Otherwise it stays, or goes to `ST_FINISH` on timeout. In toggle mode it always moves to `ST_POLL_B`.
- `ST_POLL_B`. If bit 6 is equal in both reads it moves to `ST_VERIFY`. Otherwise it returns to `ST_POLL_A`, or goes to `ST_FINISH` on timeout.
- `ST_VERIFY`. After the read-back it moves to `ST_FINISH`.
- `ST_FINISH`. It returns to `ST_IDLE`.

The bus-cycle engine has these states:
- `BC_IDLE` leads to `BC_W_SETUP`, `BC_W_LOW` and `BC_W_HIGH` for a write.
- `BC_IDLE` leads to `BC_R_TURN`, `BC_R_LOW` and `BC_R_END` for a read.

Top module: `flash_pe_ctrl`

## Requirements
- R1: With `req_op`=0 (program), the block writes exactly four bus words, in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R2: With `req_op`=1 (sector erase), the block writes exactly six words, in this order: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then the request address with 30h.
- R3: With `req_op`=2 (chip erase; code 3 behaves the same), the block writes the same first five words as R2, then 5555h/10h.
- R4: With `poll_toggle`=0, the block reads the request address repeatedly until bit 7 of the read equals bit 7 of the expected byte. That is one read per poll.
- R5: With `poll_toggle`=1, each poll is two back-to-back reads of the request address. Completion is declared when bit 6 is equal in both reads.
- R6: After completion, one extra read of the request address is made. `verify_fail` is set if that byte differs from the expected byte. The expected byte is the request data for a program, and FFh for either erase.
- R7: If `MAX_POLLS` polls finish without completion, `done` pulses with `timeout`=1 and no verify read is made.
- R8: During a write, OE is high, and CE and WE are both low for at least `WE_LOW_CLKS` clocks. Address and data stay constant while both are low. WE stays high for at least `WE_HIGH_CLKS` clocks between writes.
- R9: During a read, WE is high. The data bus is released for at least one clock before OE falls.
- R10: The data bus is driven only while CE is low and OE is high, which is a write cycle, and never while OE is low.
- R11: Under reset, CE, OE and WE are high, the bus is not driven, and `busy` and `done` are low.
- R12: `busy` rises the clock after a request is accepted and stays high through the `done` cycle. A request presented while busy is ignored.
- R13: `verify_fail` and `timeout` keep their values after `done` until the next request is accepted, and are both cleared at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| poll_toggle | input | 1 | 0 bit-7 polling, 1 bit-6 double-read polling |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| verify_fail | output | 1 | Read-back mismatch of last request |
| timeout | output | 1 | Poll limit reached on last request |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data to flash |
| fl_dq_oe | output | 1 | Drive enable for the data bus |
| fl_dq_in | input | 8 | Data from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The hardest outcomes to reach from the ports are a poll timeout and a read-back mismatch. A well-behaved flash model finishes every operation, and it ends up holding whatever was written. The bench's flash model is therefore told, before each request, how many status reads it should answer as busy. For the timeout tests that count is far above a deliberately small `MAX_POLLS`. For the mismatch test, the model programs by clearing bits only, and a byte is programmed over one that is not erased. The bit-wise AND then differs from the requested value while the toggle bits still settle normally.

// File: rtl/flash_pe_pkg.sv
`timescale 1ns/1ps
package flash_pe_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_CHIP_ALT = 2'd3
    } pe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL_A,
        ST_POLL_B,
        ST_VERIFY,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [2:0] {
        BC_IDLE,
        BC_W_SETUP,
        BC_W_LOW,
        BC_W_HIGH,
        BC_R_TURN,
        BC_R_LOW,
        BC_R_END
    } bc_state_e;

    // One command-table entry: a fixed word, or the caller's address/data
    typedef struct packed {
        logic        use_tgt;
        logic        use_wd;
        logic [15:0] caddr;
        logic [7:0]  cdata;
    } cmd_word_t;

    function automatic logic [2:0] cmd_count(pe_op_e op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

    function automatic cmd_word_t cmd_entry(pe_op_e op, logic [2:0] idx);
        cmd_word_t w;
        w = '{use_tgt: 1'b0, use_wd: 1'b0, caddr: 16'h5555, cdata: 8'hAA};
        unique case (idx)
            3'd0: ;
            3'd1: begin w.caddr = 16'h2AAA; w.cdata = 8'h55; end
            3'd2: w.cdata = (op == OP_PROG) ? 8'hA0 : 8'h80;
            3'd3: begin
                if (op == OP_PROG) begin
                    w.use_tgt = 1'b1;
                    w.use_wd  = 1'b1;
                end
            end
            3'd4: begin w.caddr = 16'h2AAA; w.cdata = 8'h55; end
            3'd5: begin
                if (op == OP_SECT) begin
                    w.use_tgt = 1'b1;
                    w.cdata   = 8'h30;
                end else begin
                    w.cdata   = 8'h10;
                end
            end
            default: ;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
`timescale 1ns/1ps
module flash_bus_cycle
    import flash_pe_pkg::*;
#(
    parameter int AW           = 17,
    parameter int WE_LOW_CLKS  = 2,
    parameter int WE_HIGH_CLKS = 1,
    parameter int READ_CLKS    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          cyc_done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);

    localparam int MAXC = (WE_LOW_CLKS > WE_HIGH_CLKS) ?
                          ((WE_LOW_CLKS > READ_CLKS) ? WE_LOW_CLKS : READ_CLKS) :
                          ((WE_HIGH_CLKS > READ_CLKS) ? WE_HIGH_CLKS : READ_CLKS);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LOW_LAST  = CW'(WE_LOW_CLKS - 1);
    localparam logic [CW-1:0] HIGH_LAST = CW'(WE_HIGH_CLKS - 1);
    localparam logic [CW-1:0] READ_LAST = CW'(READ_CLKS - 1);

    bc_state_e     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [7:0]    rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= BC_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (state == BC_IDLE && start) begin
                addr_q <= addr;
                data_q <= wdata;
            end
            if (state == BC_R_LOW && cnt == READ_LAST)
                rdata_q <= fl_dq_in;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            BC_IDLE: begin
                cnt_nxt = '0;
                if (start) nxt = rd ? BC_R_TURN : BC_W_SETUP;
            end
            BC_W_SETUP: begin nxt = BC_W_LOW; cnt_nxt = '0; end
            BC_W_LOW: begin
                if (cnt == LOW_LAST) begin nxt = BC_W_HIGH; cnt_nxt = '0; end
                else cnt_nxt = cnt + CW'(1);
            end
            BC_W_HIGH: begin
                if (cnt == HIGH_LAST) nxt = BC_IDLE;
                else cnt_nxt = cnt + CW'(1);
            end
            BC_R_TURN: begin nxt = BC_R_LOW; cnt_nxt = '0; end
            BC_R_LOW: begin
                if (cnt == READ_LAST) nxt = BC_R_END;
                else cnt_nxt = cnt + CW'(1);
            end
            BC_R_END: nxt = BC_IDLE;
            default:  nxt = BC_IDLE;
        endcase
    end

    always_comb begin
        fl_addr   = addr_q;
        fl_dq_out = data_q;
        rdata     = rdata_q;
        fl_ce_n   = !(state inside {BC_W_SETUP, BC_W_LOW, BC_W_HIGH, BC_R_LOW});
        fl_we_n   = (state != BC_W_LOW);
        fl_oe_n   = (state != BC_R_LOW);
        fl_dq_oe  = (state inside {BC_W_SETUP, BC_W_LOW, BC_W_HIGH});
        cyc_done  = ((state == BC_W_HIGH) && (cnt == HIGH_LAST)) || (state == BC_R_END);
    end

endmodule

// File: rtl/flash_pe_ctrl.sv
`timescale 1ns/1ps
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int AW           = 17,
    parameter int WE_LOW_CLKS  = 2,
    parameter int WE_HIGH_CLKS = 1,
    parameter int READ_CLKS    = 5,
    parameter int MAX_POLLS    = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          poll_toggle,
    output logic          busy,
    output logic          done,
    output logic          verify_fail,
    output logic          timeout,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);

    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

    seq_state_e    state, nxt;
    pe_op_e        op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          mode_q;
    logic [2:0]    idx_q;
    logic          pend_q;
    logic [PW-1:0] poll_q;
    logic          bit6_q;
    logic          vfail_q, tout_q;

    logic          cyc_start, cyc_rd, cyc_done;
    logic [AW-1:0] cyc_addr;
    logic [7:0]    cyc_wdata, cyc_rdata;
    logic [7:0]    exp_byte;
    cmd_word_t     cw;
    logic          last_poll;

    assign exp_byte  = (op_q == OP_PROG) ? data_q : 8'hFF;
    assign cw        = cmd_entry(op_q, idx_q);
    assign last_poll = (poll_q == POLL_LAST);

    flash_bus_cycle #(
        .AW(AW), .WE_LOW_CLKS(WE_LOW_CLKS),
        .WE_HIGH_CLKS(WE_HIGH_CLKS), .READ_CLKS(READ_CLKS)
    ) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .start(cyc_start), .rd(cyc_rd), .addr(cyc_addr), .wdata(cyc_wdata),
        .cyc_done(cyc_done), .rdata(cyc_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_CMD;
            ST_CMD: if (cyc_done && idx_q == cmd_count(op_q) - 3'd1) nxt = ST_POLL_A;
            ST_POLL_A: begin
                if (cyc_done) begin
                    if (mode_q)                              nxt = ST_POLL_B;
                    else if (cyc_rdata[7] == exp_byte[7])    nxt = ST_VERIFY;
                    else if (last_poll)                      nxt = ST_FINISH;
                end
            end
            ST_POLL_B: begin
                if (cyc_done) begin
                    if (cyc_rdata[6] == bit6_q) nxt = ST_VERIFY;
                    else if (last_poll)         nxt = ST_FINISH;
                    else                        nxt = ST_POLL_A;
                end
            end
            ST_VERIFY: if (cyc_done) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            mode_q  <= 1'b0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            poll_q  <= '0;
            bit6_q  <= 1'b0;
            vfail_q <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (cyc_start)     pend_q <= 1'b1;
            else if (cyc_done) pend_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    op_q    <= pe_op_e'(req_op);
                    addr_q  <= req_addr;
                    data_q  <= req_data;
                    mode_q  <= poll_toggle;
                    idx_q   <= '0;
                    poll_q  <= '0;
                    vfail_q <= 1'b0;
                    tout_q  <= 1'b0;
                end
                ST_CMD: if (cyc_done) idx_q <= idx_q + 3'd1;
                ST_POLL_A: if (cyc_done) begin
                    bit6_q <= cyc_rdata[6];
                    if (!mode_q && cyc_rdata[7] != exp_byte[7]) begin
                        if (last_poll) tout_q <= 1'b1;
                        else           poll_q <= poll_q + PW'(1);
                    end
                end
                ST_POLL_B: if (cyc_done && cyc_rdata[6] != bit6_q) begin
                    if (last_poll) tout_q <= 1'b1;
                    else           poll_q <= poll_q + PW'(1);
                end
                ST_VERIFY: if (cyc_done) vfail_q <= (cyc_rdata != exp_byte);
                default: ;
            endcase
        end
    end

    always_comb begin
        cyc_start   = (state inside {ST_CMD, ST_POLL_A, ST_POLL_B, ST_VERIFY}) && !pend_q;
        cyc_rd      = (state != ST_CMD);
        cyc_addr    = (state != ST_CMD || cw.use_tgt) ? addr_q : AW'(cw.caddr);
        cyc_wdata   = cw.use_wd ? data_q : cw.cdata;
        busy        = (state != ST_IDLE);
        done        = (state == ST_FINISH);
        verify_fail = vfail_q;
        timeout     = tout_q;
    end

endmodule

// File: rtl/flash_pe_ctrl_chk.sv
`timescale 1ns/1ps
module flash_pe_ctrl_chk #(
    parameter int AW          = 17,
    parameter int WE_LOW_CLKS = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          verify_fail,
    input logic          timeout,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_dq_out,
    input logic          fl_dq_oe,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n
);

    logic [15:0] we_low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              we_low_run <= '0;
        else if (!fl_we_n)       we_low_run <= (we_low_run == 16'hFFFF) ? we_low_run : we_low_run + 16'd1;
        else                     we_low_run <= '0;
    end

    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_oe_n);  // R8
    AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (we_low_run >= 16'(WE_LOW_CLKS)));  // R8
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !fl_ce_n && $past(!fl_we_n && !fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));  // R8
    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> fl_we_n);  // R9
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_oe_n) |-> $past(!fl_dq_oe));  // R9
    AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_dq_oe |-> (!fl_ce_n && fl_oe_n));  // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R12
    AST_NO_VERIFY_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(timeout && verify_fail));  // R7

endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.AW(AW), .WE_LOW_CLKS(WE_LOW_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .verify_fail(verify_fail), .timeout(timeout),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/flash_pe_ctrl_tb.sv
`timescale 1ns/1ps
module flash_pe_ctrl_tb;

    localparam int AW   = 17;
    localparam int MAXP = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          poll_toggle = 1'b0;
    logic          busy, done, verify_fail, timeout;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out;
    logic          fl_dq_oe;
    logic [7:0]    fl_dq_in;
    logic          fl_ce_n, fl_oe_n, fl_we_n;

    always #10 clk = ~clk;

    flash_pe_ctrl #(.AW(AW), .MAX_POLLS(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .poll_toggle(poll_toggle),
        .busy(busy), .done(done), .verify_fail(verify_fail), .timeout(timeout),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural flash model ----------------
    logic [7:0]     mem [int];
    logic [AW+7:0]  wlog [$];
    logic [AW-1:0]  wr_addr, pa;
    logic [7:0]     wr_dat, pd, rd_val = 8'h00;
    bit             prev_wr, prev_rd, prev_dq_oe, tog;
    int             wr_low, we_gap = 100;
    int             n_wr, n_reads, seq_len = 4, arm_busy, busy_left, arm_op, pop;
    bit             mb, prev_req, prev_done, prev_mb;

    assign fl_dq_in = rd_val;

    function automatic logic [7:0] mem_rd(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    task automatic commit();
        if (pop == 0) mem[int'(pa)] = mem_rd(int'(pa)) & pd;
        else if (pop == 1) begin
            for (int i = 0; i < 512; i++) mem[(int'(pa) & ~511) | i] = 8'hFF;
        end else mem.delete();
    endtask

    always @(negedge clk) begin
        bit wr, rd;
        if (!rst_n) begin
            prev_wr = 0; prev_rd = 0; prev_dq_oe = 0; we_gap = 100;
            mb = 0; prev_req = 0; prev_done = 0; prev_mb = 0;
        end else begin
            wr = !fl_ce_n && !fl_we_n;
            rd = !fl_ce_n && !fl_oe_n;
            if (!fl_we_n) chk(fl_oe_n, "R8", "OE during write", fl_oe_n, 1);
            if (!fl_oe_n) begin
                chk(fl_we_n, "R9", "WE during read", fl_we_n, 1);
                chk(!fl_dq_oe, "R10", "bus driven in read", fl_dq_oe, 0);
            end
            if (fl_dq_oe) chk(!fl_ce_n && fl_oe_n, "R10", "drive outside write", {fl_ce_n, fl_oe_n}, 1);
            if (wr && !prev_wr) begin
                chk(we_gap >= 1, "R8", "WE high gap", we_gap, 1);
                chk(fl_dq_oe, "R10", "bus not driven in write", fl_dq_oe, 1);
                wr_addr = fl_addr; wr_dat = fl_dq_out; wr_low = 1;
            end else if (wr) begin
                chk(fl_addr == wr_addr, "R8", "addr hold", int'(fl_addr), int'(wr_addr));
                chk(fl_dq_out == wr_dat, "R8", "data hold", fl_dq_out, wr_dat);
                wr_low++;
            end else if (prev_wr) begin
                chk(wr_low >= 2, "R8", "WE low width", wr_low, 2);
                wlog.push_back({wr_addr, wr_dat});
                n_wr++;
                if (n_wr == seq_len) begin
                    pa = wr_addr; pd = wr_dat; pop = arm_op;
                    if (arm_busy == 0) commit();
                    else busy_left = arm_busy;
                end
            end
            we_gap = fl_we_n ? we_gap + 1 : 0;
            if (rd && !prev_rd) begin
                chk(!prev_dq_oe, "R9", "turnaround", prev_dq_oe, 0);
                n_reads++;
                if (busy_left > 0) begin
                    tog = !tog;
                    rd_val = {(pop == 0) ? ~pd[7] : 1'b0, tog, 6'h00};
                    busy_left--;
                    if (busy_left == 0) commit();
                end else rd_val = mem_rd(int'(fl_addr));
            end
            // busy reference, advanced once per clock
            if (prev_req && !prev_mb) mb = 1;
            else if (prev_done) mb = 0;
            chk(busy == mb, "R12", "busy", busy, mb);
            prev_req = req_valid; prev_done = done; prev_mb = mb;
            prev_wr = wr; prev_rd = rd; prev_dq_oe = fl_dq_oe;
        end
    end

    function automatic logic [AW+7:0] exp_word(int op, int i, int a, int d);
        logic [15:0] ca; logic [7:0] cd;
        ca = (i == 1 || i == 4) ? 16'h2AAA : 16'h5555;
        cd = (i == 1 || i == 4) ? 8'h55 : 8'hAA;
        if (i == 2) cd = (op == 0) ? 8'hA0 : 8'h80;
        if (op == 0 && i == 3) return {AW'(a), 8'(d)};
        if (i == 5) return (op == 1) ? {AW'(a), 8'h30} : {AW'(16'h5555), 8'h10};
        return {AW'(ca), cd};
    endfunction

    task automatic run_op(input int op, input int a, input int d, input bit tg, input int bb,
                          input int exp_reads, input bit exp_vf, input bit exp_to,
                          input int inject_at, input string tag);
        int  cyc;
        bit  seen;
        string rq;
        rq = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
        wlog.delete(); n_wr = 0; n_reads = 0;
        seq_len = (op == 0) ? 4 : 6; arm_op = op; arm_busy = bb;
        @(posedge clk); #2;
        req_valid = 1; req_op = op[1:0]; req_addr = a[AW-1:0]; req_data = d[7:0]; poll_toggle = tg;
        @(posedge clk); #2;
        req_valid = 0; req_op = 2'd3; req_data = 8'h00;
        chk(!timeout && !verify_fail, "R13", {tag, " flags cleared on accept"}, {timeout, verify_fail}, 0);
        cyc = 0; seen = 0;
        while (!seen && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (done) seen = 1;
            if (inject_at != 0 && cyc == inject_at) begin req_valid = 1; req_op = 2'd2; end
            if (inject_at != 0 && cyc == inject_at + 3) req_valid = 0;
        end
        chk(seen, "R12", {tag, " done seen"}, seen, 1);
        chk(timeout == exp_to, "R7", {tag, " timeout"}, timeout, exp_to);
        chk(verify_fail == exp_vf, "R6", {tag, " verify_fail"}, verify_fail, exp_vf);
        chk(n_reads == exp_reads, tg ? "R5" : "R4", {tag, " read count"}, n_reads, exp_reads);
        chk(wlog.size() == seq_len, rq, {tag, " write count"}, wlog.size(), seq_len);
        for (int i = 0; i < wlog.size() && i < seq_len; i++)
            chk(wlog[i] == exp_word(op, i, a, d), rq, {tag, " write word"}, int'(wlog[i]), int'(exp_word(op, i, a, d)));
        busy_left = 0;
        req_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(fl_ce_n && fl_oe_n && fl_we_n, "R11", "strobes in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
        chk(!fl_dq_oe, "R11", "bus released in reset", fl_dq_oe, 0);
        chk(!busy && !done, "R11", "busy/done in reset", {busy, done}, 0);
        @(posedge clk); #2; rst_n = 1;
        repeat (2) @(negedge clk);

        run_op(0, 'h01234, 'h5A, 0, 3, 5, 0, 0, 0, "program data-poll");
        chk(mem_rd('h01234) == 8'h5A, "R1", "byte programmed", mem_rd('h01234), 8'h5A);
        run_op(0, 'h1F00F, 'hC3, 1, 4, 7, 0, 0, 0, "program toggle");
        run_op(0, 'h01234, 'hA5, 1, 2, 5, 1, 0, 0, "program over data");
        run_op(1, 'h01234, 'h00, 0, 5, 7, 0, 0, 0, "sector erase");
        chk(mem_rd('h01200) == 8'hFF, "R2", "sector erased", mem_rd('h01200), 8'hFF);
        run_op(0, 'h00010, 'h77, 0, 6, 8, 0, 0, 10, "busy ignore");
        run_op(2, 'h00100, 'h00, 1, 0, 3, 0, 0, 0, "chip erase");
        run_op(0, 'h00200, 'h3C, 0, 1000, MAXP, 0, 1, 0, "timeout data-poll");
        run_op(0, 'h00300, 'h3C, 1, 1000, 2 * MAXP, 0, 1, 0, "timeout toggle");
        repeat (10) @(negedge clk);
        chk(timeout == 1'b1, "R13", "timeout held", timeout, 1);
        run_op(0, 'h00020, 'h11, 0, 1, 3, 0, 0, 0, "final program");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule